// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Link

This block moves 8-bit words over a two-pin synchronous link made of a clock line and a data line. A word written by the host goes into a transmit buffer. The engine copies it into a shift register and shifts it out most significant bit first. In the receive direction, each completed word is copied into a receive buffer. The host works through a small register port with three addresses: a control byte, a data address (write fills the transmit buffer, read empties the receive buffer) and a status byte. Each finished word raises a one-cycle interrupt pulse.

The engine has two framings. In plain mode, words are shifted with no framing. In framed mode, a message opens with a start condition and closes with a stop condition. A start is the data line falling while the clock is high. A stop is the data line rising while the clock is high. Clearing the run bit lets the current word finish, then closes the message. The half-period of the serial clock is one tick of a selectable source:
- the system clock;
- a timer tick;
- a prescaler tick;
- every second edge of a toggle level.

An external clock can also drive the clock pin. In that case the block does not drive the clock pin, and it shifts on the synchronised edges of the external clock. A separate output carries the serial data stream to a modulator. A one-cycle end-of-message pulse tells the modulator that the last word has gone out with nothing left in the transmit buffer.

The control FSM has six states:
- S_IDLE: bus at rest, clock high.
- S_START: data low, clock high.
- S_LOW: clock low, data presented.
- S_HIGH: clock high, data held and sampled.
- S_STOP_L: clock low, data low.
- S_STOP_H: clock high, data low.

Each transition happens on a tick:
- S_IDLE→S_START, or S_IDLE→S_LOW in plain or external mode, when work is pending. Work is pending when run is set and, for transmit, the buffer is full. This transition loads the shift register.
- S_START→S_LOW.
- S_LOW→S_HIGH.
- S_HIGH→S_LOW after bits 0 to 6. After bit 7 the next state depends on what is pending:
  - S_HIGH→S_LOW with a reload, if work is still pending.
  - Otherwise S_HIGH→S_STOP_L in framed mode.
  - Otherwise S_HIGH→S_IDLE in plain or external mode.
- S_STOP_L→S_STOP_H.
- S_STOP_H→S_IDLE. This transition is the stop edge.

Top module: `ssi_link`

## Requirements
- R1: After reset the control byte at address 0 reads 0x02 (bit1 = transmit direction set, run bit0 clear). The status byte at address 2 reads 0x01, with bit0 = ready and bit1 = active. The clock pin is driven high and the data pin is high.
- R2: Bits go out and come in MSB first. Data changes only while the clock is low and is taken on the clock's rising edge.
- R3: In framed mode (control bit2 = 1, bit5 = 0), each message starts with the data line falling while the clock stays high.
- R4: A framed message ends with the data line rising while the clock stays high. After that the bus rests with both lines high.
- R5: A word written while the previous one is shifting is sent directly after it, within the same message. There is exactly one interrupt pulse per completed word.
- R6: Status bit0 means "transmit buffer empty" in the transmit direction (control bit1 = 1). A write to address 1 clears it. In the receive direction it means "receive buffer full", and a read of address 1 clears it.
- R7: Clearing the run bit (control bit0) mid-word lets that word finish. Then the stop condition follows, and no further word is started.
- R8: In the receive direction, every completed word overwrites the receive buffer, including the final word of a terminated message.
- R9: The end-of-message output pulses for one cycle when a transmitted word completes with the transmit buffer empty.
- R10: Control bits 4:3 select the tick source: 0 the system clock, 1 the timer tick, 2 the prescaler tick, 3 the rising edges of the toggle level. One tick lasts one clock half-period.
- R11: With control bit5 set, the clock pin is never driven. The word is shifted on the edges of the external clock, starting at its first falling edge.
- R12: In plain mode (control bit2 = 0), no start or stop condition ever appears on the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read of address 1 empties receive buffer) |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tmr_tick | input | 1 | Timer tick source |
| pre_tick | input | 1 | Prescaler tick source |
| tog_lvl | input | 1 | Toggle level; its rising edges form a tick source |
| sc_i | input | 1 | Clock pin level |
| sc_o | output | 1 | Clock pin drive value |
| sc_oe | output | 1 | Clock pin drive enable |
| sd_i | input | 1 | Data pin level |
| sd_o | output | 1 | Data pin drive value |
| sd_oe | output | 1 | Data pin drive enable |
| mod_data | output | 1 | Serial data stream to modulator |
| msg_end | output | 1 | Last word sent with empty buffer |
| irq | output | 1 | One-cycle pulse per completed word |

## Verification
A wrong state in the FSM shows on the pins within one tick:
- A missed S_START, or a stray S_STOP_L/S_STOP_H pass, adds or drops a start or stop edge. A pin monitor counts these per message.
- A bit counter that is off by one shifts the captured byte and moves the interrupt by one bit time. That is visible when the first word completes.
- Buffer-flag errors show as a wrong status byte at the next poll, or as a word sent twice or never.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
    localparam int WORD_W = 8;

    // control byte field positions (host-visible encoding)
    localparam int CF_RUN  = 0;
    localparam int CF_TX   = 1;
    localparam int CF_LINK = 2;
    localparam int CF_SRC  = 3;   // two bits: 4:3
    localparam int CF_EXT  = 5;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_LOW,
        S_HIGH,
        S_STOP_L,
        S_STOP_H
    } ssi_state_e;
endpackage

// File: rtl/ssi_tick_gen.sv
module ssi_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       ext,
    input  logic       tmr_tick,
    input  logic       pre_tick,
    input  logic       tog_lvl,
    input  logic       sc_i,
    input  logic       sd_i,
    output logic       tick,
    output logic       sc_lvl,
    output logic       sd_lvl
);
    logic [SYNC_STAGES-1:0] sc_sync, sd_sync;
    logic sc_prev, tog_prev, int_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_sync  <= '1;
            sd_sync  <= '1;
            sc_prev  <= 1'b1;
            tog_prev <= 1'b0;
        end else begin
            sc_sync  <= {sc_sync[SYNC_STAGES-2:0], sc_i};
            sd_sync  <= {sd_sync[SYNC_STAGES-2:0], sd_i};
            sc_prev  <= sc_lvl;
            tog_prev <= tog_lvl;
        end
    end

    assign sc_lvl = sc_sync[SYNC_STAGES-1];
    assign sd_lvl = sd_sync[SYNC_STAGES-1];

    always_comb begin
        unique case (src)
            2'd0:    int_tick = 1'b1;
            2'd1:    int_tick = tmr_tick;
            2'd2:    int_tick = pre_tick;
            default: int_tick = tog_lvl & ~tog_prev;
        endcase
    end

    assign tick = ext ? (sc_lvl ^ sc_prev) : int_tick;
endmodule

// File: rtl/ssi_shift_fsm.sv
module ssi_shift_fsm
    import ssi_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         tx_dir,
    input  logic         link,
    input  logic         ext,
    input  logic         sc_lvl,
    input  logic         tx_full,
    input  logic [W-1:0] tx_word,
    input  logic         sd_in,
    output ssi_state_e   st,
    output logic         load,
    output logic         word_done,
    output logic [W-1:0] rx_word,
    output logic         sc_drv,
    output logic         sc_en,
    output logic         sd_drv,
    output logic         sd_en,
    output logic         msg_end,
    output logic         ser_out
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    ssi_state_e nxt;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] bitcnt;
    logic             hold_bit;
    logic             go, framed;

    assign framed = link & ~ext;
    assign go     = run & (~tx_dir | tx_full);

    // next state
    always_comb begin
        nxt       = st;
        load      = 1'b0;
        word_done = 1'b0;
        unique case (st)
            S_IDLE: if (tick && go && (!ext || !sc_lvl)) begin
                load = 1'b1;
                nxt  = framed ? S_START : S_LOW;
            end
            S_START:  if (tick) nxt = S_LOW;
            S_LOW:    if (tick) nxt = S_HIGH;
            S_HIGH: if (tick) begin
                if (bitcnt == LAST_BIT) begin
                    word_done = 1'b1;
                    if (go) begin
                        load = 1'b1;
                        nxt  = S_LOW;
                    end else begin
                        nxt = framed ? S_STOP_L : S_IDLE;
                    end
                end else begin
                    nxt = S_LOW;
                end
            end
            S_STOP_L: if (tick) nxt = S_STOP_H;
            S_STOP_H: if (tick) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            shreg    <= '1;
            bitcnt   <= '0;
            hold_bit <= 1'b1;
        end else begin
            st <= nxt;
            if (load) begin
                shreg  <= tx_dir ? tx_word : '1;
                bitcnt <= '0;
            end else if (st == S_HIGH && tick) begin
                shreg  <= rx_word;
                bitcnt <= bitcnt + 1'b1;
            end
            if (st == S_LOW) hold_bit <= shreg[W-1];
        end
    end

    assign rx_word = {shreg[W-2:0], sd_in};
    assign msg_end = word_done & tx_dir & ~tx_full;

    // pin outputs
    always_comb begin
        sc_en   = ~ext;
        sc_drv  = 1'b1;
        sd_drv  = 1'b1;
        sd_en   = tx_dir;
        ser_out = 1'b1;
        unique case (st)
            S_IDLE: begin
                sd_drv = framed ? 1'b1 : hold_bit;
                sd_en  = tx_dir | ~ext;
            end
            S_START: begin
                sd_drv = 1'b0;
                sd_en  = 1'b1;
            end
            S_LOW: begin
                sc_drv  = 1'b0;
                sd_drv  = shreg[W-1];
                ser_out = shreg[W-1];
            end
            S_HIGH: begin
                sd_drv  = shreg[W-1];
                ser_out = shreg[W-1];
            end
            S_STOP_L: begin
                sc_drv = 1'b0;
                sd_drv = 1'b0;
                sd_en  = 1'b1;
            end
            S_STOP_H: begin
                sd_drv = 1'b0;
                sd_en  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ssi_link.sv
module ssi_link
    import ssi_pkg::*;
#(
    parameter int W           = WORD_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         tmr_tick,
    input  logic         pre_tick,
    input  logic         tog_lvl,
    input  logic         sc_i,
    output logic         sc_o,
    output logic         sc_oe,
    input  logic         sd_i,
    output logic         sd_o,
    output logic         sd_oe,
    output logic         mod_data,
    output logic         msg_end,
    output logic         irq
);
    localparam logic [W-1:0] CFG_RST = W'(1) << CF_TX;

    logic [W-1:0] cfg, tx_buf, rx_buf, rx_word;
    logic         tx_full, rx_full;
    logic         tick, sc_lvl, sd_lvl, load, word_done;
    ssi_state_e   st;

    wire tx_dir = cfg[CF_TX];
    wire ext    = cfg[CF_EXT];

    ssi_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .src(cfg[CF_SRC+1:CF_SRC]), .ext(ext),
        .tmr_tick(tmr_tick), .pre_tick(pre_tick), .tog_lvl(tog_lvl),
        .sc_i(sc_i), .sd_i(sd_i), .tick(tick), .sc_lvl(sc_lvl), .sd_lvl(sd_lvl)
    );

    ssi_shift_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(cfg[CF_RUN]),
        .tx_dir(tx_dir), .link(cfg[CF_LINK]), .ext(ext), .sc_lvl(sc_lvl),
        .tx_full(tx_full), .tx_word(tx_buf), .sd_in(ext ? sd_lvl : sd_i),
        .st(st), .load(load), .word_done(word_done), .rx_word(rx_word),
        .sc_drv(sc_o), .sc_en(sc_oe), .sd_drv(sd_o), .sd_en(sd_oe),
        .msg_end(msg_end), .ser_out(mod_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg     <= CFG_RST;
            tx_buf  <= '0;
            tx_full <= 1'b0;
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADDR_CTRL) cfg <= reg_wdata;
            if (reg_wr && reg_addr == ADDR_DATA) begin
                tx_buf  <= reg_wdata;
                tx_full <= 1'b1;
            end else if (load && tx_dir) begin
                tx_full <= 1'b0;
            end
            if (word_done && !tx_dir) begin
                rx_buf  <= rx_word;
                rx_full <= 1'b1;
            end else if (reg_rd && reg_addr == ADDR_DATA) begin
                rx_full <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = cfg;
            ADDR_DATA: reg_rdata = rx_buf;
            ADDR_STAT: reg_rdata = {{(W-2){1'b0}}, st != S_IDLE,
                                    tx_dir ? ~tx_full : rx_full};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = word_done;
endmodule

// File: rtl/ssi_link_chk.sv
module ssi_link_chk
    import ssi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sc_o,
    input logic       sc_oe,
    input logic       sd_o,
    input logic       msg_end,
    input logic       irq,
    input ssi_state_e st
);
    // R3: start condition shape
    p_start_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_START) |-> (sc_oe && sc_o && !sd_o));

    // R2: data held for the whole clock-high phase
    p_sd_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HIGH && $past(st) == S_HIGH) |-> $stable(sd_o));

    // R4: bus released high after the stop phase
    p_stop_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == S_STOP_H && st == S_IDLE) |-> (sc_o && sd_o));

    // R9: no further data bit after end of message
    p_msg_end_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_end |=> (st != S_LOW));

    // R5: one-cycle interrupt per word
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind ssi_link ssi_link_chk u_chk (.*);

// File: tb/ssi_link_bench.sv
module ssi_link_bench;
    import ssi_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tmr_tick = 1'b0, pre_tick = 1'b0, tog_lvl = 1'b0;
    logic       sc_o, sc_oe, sd_o, sd_oe, mod_data, msg_end, irq;
    logic       ext_sc = 1'b1, bench_sd = 1'b1, rx_drive = 1'b0;
    wire        sc_bus = sc_oe ? sc_o : ext_sc;
    wire        sd_bus = sd_oe ? sd_o : bench_sd;

    ssi_link u_ssi_link (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tmr_tick(tmr_tick), .pre_tick(pre_tick), .tog_lvl(tog_lvl),
        .sc_i(sc_bus), .sc_o(sc_o), .sc_oe(sc_oe), .sd_i(sd_bus),
        .sd_o(sd_o), .sd_oe(sd_oe), .mod_data(mod_data),
        .msg_end(msg_end), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    int mon_n, mon_words, starts, stops, irqs, ends, low_cnt, last_low;
    logic [7:0] mon_sh;
    logic [7:0] mon_bytes [4];
    logic [7:0] rx_pat [4];
    logic prev_sc = 1'b1, prev_sd = 1'b1, sc_driven = 1'b0;

    // timer tick: one pulse every 5 cycles, moved off the edge
    always begin
        repeat (4) @(negedge clk);
        #2 tmr_tick = 1'b1;
        @(negedge clk);
        #2 tmr_tick = 1'b0;
    end

    // pin monitor
    always @(negedge clk) begin
        logic cs, cd;
        cs = sc_bus;
        cd = sd_bus;
        if (prev_sc && cs && prev_sd && !cd) starts++;
        if (prev_sc && cs && !prev_sd && cd) stops++;
        if (!prev_sc && cs) begin
            mon_sh = {mon_sh[6:0], cd};
            mon_n++;
            last_low = low_cnt;
            low_cnt = 0;
            if (mon_n % 8 == 0 && mon_words < 4) begin
                mon_bytes[mon_words] = mon_sh;
                mon_words++;
            end
        end
        if (!cs) low_cnt++;
        if (irq) irqs++;
        if (msg_end) ends++;
        if (sc_oe) sc_driven = 1'b1;
        if (rx_drive && !cs) bench_sd = rx_pat[(mon_n / 8) % 4][7 - (mon_n % 8)];
        prev_sc = cs;
        prev_sd = cd;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic mon_clear();
        mon_n = 0; mon_words = 0; starts = 0; stops = 0; irqs = 0;
        ends = 0; low_cnt = 0; last_low = 0; mon_sh = 8'h00;
        sc_driven = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); #1;
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        check("R1 sc_o", sc_o, 1);
        check("R1 sc_oe", sc_oe, 1);
        check("R1 sd_o", sd_o, 1);
        rd(ADDR_CTRL, v); check("R1 control", v, 8'h02);
        rd(ADDR_STAT, v); check("R1 status", v, 8'h01);
        wr(ADDR_DATA, 8'h55);
        rd(ADDR_STAT, v); check("R6 tx write clears ready", v, 8'h00);
    endtask

    task automatic t_link_tx();
        logic [7:0] v;
        wr(ADDR_CTRL, 8'h06);
        wait_cyc(5);
        mon_clear();
        wr(ADDR_DATA, 8'hA5);
        wr(ADDR_CTRL, 8'h07);
        v = 8'h00;
        for (int i = 0; i < 50 && v[0] == 1'b0; i++) rd(ADDR_STAT, v);
        wr(ADDR_DATA, 8'h3C);
        wait_cyc(80);
        check("R2 first word", mon_bytes[0], 8'hA5);
        check("R5 second word", mon_bytes[1], 8'h3C);
        check("R5 word count", mon_words, 2);
        check("R3 starts", starts, 1);
        check("R4 stops", stops, 1);
        check("R5 irq count", irqs, 2);
        check("R9 msg_end count", ends, 1);
        check("R4 rest sc", sc_bus, 1);
        check("R4 rest sd", sd_bus, 1);
        rd(ADDR_STAT, v); check("R4 idle status", v, 8'h01);
    endtask

    task automatic t_plain_tx();
        wr(ADDR_CTRL, 8'h02);
        wait_cyc(5);
        mon_clear();
        wr(ADDR_DATA, 8'hA6);
        wr(ADDR_CTRL, 8'h03);
        wait_cyc(60);
        check("R12 word", mon_bytes[0], 8'hA6);
        check("R12 starts", starts, 0);
        check("R12 stops", stops, 0);
        check("R9 plain msg_end", ends, 1);
    endtask

    task automatic t_rx_stop();
        logic [7:0] v;
        rx_pat[0] = 8'hC3; rx_pat[1] = 8'h5A; rx_pat[2] = 8'h96; rx_pat[3] = 8'h0F;
        wr(ADDR_CTRL, 8'h04);
        wait_cyc(5);
        mon_clear();
        rx_drive = 1'b1;
        wr(ADDR_CTRL, 8'h05);
        for (int i = 0; i < 60 && mon_n < 3; i++) wait_cyc(1);
        wr(ADDR_CTRL, 8'h04);
        wait_cyc(80);
        check("R7 words after stop request", mon_words, 1);
        check("R7 irq count", irqs, 1);
        check("R7 stops", stops, 1);
        rd(ADDR_STAT, v); check("R6 rx ready set", v, 8'h01);
        rd(ADDR_DATA, v); check("R7 received word", v, 8'hC3);
        rd(ADDR_STAT, v); check("R6 rx read clears ready", v, 8'h00);
        mon_clear();
        wr(ADDR_CTRL, 8'h05);
        for (int i = 0; i < 80 && mon_n < 10; i++) wait_cyc(1);
        wr(ADDR_CTRL, 8'h04);
        wait_cyc(80);
        check("R8 irq count", irqs, 2);
        rd(ADDR_DATA, v); check("R8 last word overwrites", v, 8'h5A);
        rx_drive = 1'b0;
        bench_sd = 1'b1;
    endtask

    task automatic t_clk_src();
        wr(ADDR_CTRL, 8'h0A);
        wait_cyc(5);
        mon_clear();
        wr(ADDR_DATA, 8'h69);
        wr(ADDR_CTRL, 8'h0B);
        wait_cyc(250);
        check("R10 low phase length", last_low, 5);
        check("R10 word", mon_bytes[0], 8'h69);
        check("R10 word count", mon_words, 1);
    endtask

    task automatic t_ext();
        wr(ADDR_CTRL, 8'h22);
        wait_cyc(5);
        mon_clear();
        wr(ADDR_DATA, 8'hB1);
        wr(ADDR_CTRL, 8'h23);
        wait_cyc(5);
        repeat (9) begin
            @(negedge clk); #1 ext_sc = 1'b0;
            repeat (6) @(negedge clk);
            #1 ext_sc = 1'b1;
            repeat (5) @(negedge clk);
        end
        wait_cyc(10);
        check("R11 clock never driven", sc_driven, 0);
        check("R11 word", mon_bytes[0], 8'hB1);
        check("R11 irq count", irqs, 1);
        check("R11 msg_end count", ends, 1);
    endtask

    initial begin
        mon_clear();
        wait_cyc(5);
        @(negedge clk); #1 rst_n = 1'b1;
        t_reset();
        t_link_tx();
        t_plain_tx();
        t_rx_stop();
        t_clk_src();
        t_ext();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule